// File: doc/BRIEF.md
# Asymmetric four-slot decode steering

This block sits between a fetch queue and the micro-op path of a wide decoder. Each cycle the queue presents a window of up to four instructions, oldest in lane 0. Their lengths are already decoded, and each carries a tag and a micro-op count. The block decides in the same cycle how many of them decode together. The oldest instruction may expand to as many as four micro-ops. Every younger instruction in the group must expand to exactly one. The block reports the number taken back to the queue, which then drops that many entries.

The group ends just before the first younger instruction that needs more than one micro-op. That instruction then leads the next cycle's group. An instruction that needs more than four micro-ops is taken alone, with nothing emitted for it in that cycle. The block then switches to a streaming mode. In that mode a counter sends out placeholder micro-ops for the instruction, up to four per cycle, and accepts nothing new until the count is used up.

A ready input from downstream holds everything still. When ready is low nothing is taken and the stream counter does not advance. Provided the queue holds its window, the outputs stay the same.

Top module: `decode_steer`

## Requirements
- R1: After reset the block is in grouping mode. An empty window (lane 0 not valid) gives take_count 0 and no valid group lane.
- R2: Grouped instructions go out in order. Group lane i carries window lane i's micro-op count and tag, grp_seq is 0, and take_count equals the number of valid group lanes.
- R3: Lane 0 may group an instruction with a count of 0 to 4. Lanes 1 to 3 group only counts of 0 or 1. A count of 0 is treated as a single micro-op.
- R4: The first younger instruction (lane 1 to 3) whose count exceeds 1 ends the group just before it. take_count is then that lane's index.
- R5: If lane 0 holds a count above 4 in grouping mode with ready high, take_count is 1 and no group lane is valid. Streaming starts on the next cycle.
- R6: While streaming, each cycle shows min(4, remaining) valid lanes, starting from lane 0, each with grp_seq 1, count 1 and the tag of the streamed instruction. Across the stream these lanes add up to the instruction's count. Grouping resumes on the cycle after the last chunk has been accepted.
- R7: While streaming, take_count is 0 whatever the window holds.
- R8: With out_ready low, take_count is 0 and the stream counter keeps its value, so the same chunk is shown again on the next cycle.
- R9: Grouping stops at the first window lane that is not valid. No later lane is grouped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| win_valid | input | LANES | Valid bit per window lane, lane 0 oldest |
| win_uops | input | LANES*CNT_W | Micro-op count per lane |
| win_tag | input | LANES*TAG_W | Instruction tag per lane |
| out_ready | input | 1 | Downstream accepts this cycle's groups |
| take_count | output | clog2(LANES+1) | Instructions the queue drops this cycle |
| grp_valid | output | LANES | Valid bit per output micro-op group |
| grp_uops | output | LANES*CNT_W | Micro-op count of each group |
| grp_tag | output | LANES*TAG_W | Tag of the instruction behind each group |
| grp_seq | output | LANES | Group is a placeholder from the stream counter |

## Verification
The group outputs and take_count are combinational from the window and the registered stream state, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. Entry into streaming, each stream chunk and the return to grouping come one rising edge after the cycle that accepted them. The bench model therefore updates its own stream state only after each comparison, as if the edge had passed. A ready-low cycle leaves that model state unchanged.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;

    // Operating mode of the steering block.
    typedef enum logic {
        MODE_GROUP  = 1'b0,
        MODE_STREAM = 1'b1
    } steer_mode_e;

endpackage

// File: rtl/steer_slot_class.sv
// Classifies one window lane by the size of its micro-op expansion.
module steer_slot_class #(
    parameter int CNT_W    = 4,
    parameter int CPLX_MAX = 4
) (
    input  logic             valid_i,
    input  logic [CNT_W-1:0] uops_i,
    output logic             simple_o,
    output logic             fits_o,
    output logic             over_o
);

    always_comb begin
        simple_o = valid_i && (uops_i <= CNT_W'(1));
        fits_o   = valid_i && (uops_i <= CNT_W'(CPLX_MAX));
        over_o   = valid_i && (uops_i >  CNT_W'(CPLX_MAX));
    end

endmodule

// File: rtl/steer_group_pick.sv
// Picks the longest legal group: lane 0 up to the complex limit, then a
// run of single micro-op lanes.
module steer_group_pick #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]               simple_i,
    input  logic [LANES-1:0]               fits_i,
    input  logic [LANES-1:0]               over_i,
    output logic [LANES-1:0]               lane_en_o,
    output logic                           enter_o,
    output logic [$clog2(LANES+1)-1:0]     n_o
);

    localparam int EMIT_W = $clog2(LANES+1);

    logic run;

    always_comb begin
        run          = fits_i[0];
        lane_en_o    = '0;
        lane_en_o[0] = fits_i[0];
        for (int i = 1; i < LANES; i++) begin
            run          = run && simple_i[i];
            lane_en_o[i] = run;
        end
        n_o = '0;
        for (int i = 0; i < LANES; i++) begin
            n_o = n_o + EMIT_W'(lane_en_o[i]);
        end
        enter_o = over_i[0];
    end

endmodule

// File: rtl/steer_ucode_seq.sv
// Placeholder microcode sequencer: a counter that releases up to LANES
// micro-ops per accepted cycle.
module steer_ucode_seq
    import decode_steer_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 4,
    parameter int TAG_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [CNT_W-1:0]             start_cnt_i,
    input  logic [TAG_W-1:0]             start_tag_i,
    input  logic                         advance_i,
    output logic                         busy_o,
    output logic [$clog2(LANES+1)-1:0]   emit_n_o,
    output logic [TAG_W-1:0]             tag_o
);

    localparam int EMIT_W = $clog2(LANES+1);

    typedef struct packed {
        steer_mode_e      mode;
        logic [CNT_W-1:0] rem;
        logic [TAG_W-1:0] tag;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] chunk;

    always_comb begin
        st_d  = st_q;
        chunk = '0;
        if (st_q.mode == MODE_STREAM) begin
            chunk = (st_q.rem > CNT_W'(LANES)) ? CNT_W'(LANES) : st_q.rem;
        end
        case (st_q.mode)
            MODE_GROUP: begin
                if (start_i && advance_i) begin
                    st_d.mode = MODE_STREAM;
                    st_d.rem  = start_cnt_i;
                    st_d.tag  = start_tag_i;
                end
            end
            MODE_STREAM: begin
                if (advance_i) begin
                    st_d.rem = st_q.rem - chunk;
                    if (st_q.rem == chunk) begin
                        st_d.mode = MODE_GROUP;
                    end
                end
            end
            default: st_d.mode = MODE_GROUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_GROUP, rem: '0, tag: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.mode == MODE_STREAM);
    assign emit_n_o = EMIT_W'(chunk);
    assign tag_o    = st_q.tag;

endmodule

// File: rtl/decode_steer.sv
module decode_steer #(
    parameter int LANES    = 4,
    parameter int CNT_W    = 4,
    parameter int TAG_W    = 8,
    parameter int CPLX_MAX = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             win_valid,
    input  logic [LANES*CNT_W-1:0]       win_uops,
    input  logic [LANES*TAG_W-1:0]       win_tag,
    input  logic                         out_ready,
    output logic [$clog2(LANES+1)-1:0]   take_count,
    output logic [LANES-1:0]             grp_valid,
    output logic [LANES*CNT_W-1:0]       grp_uops,
    output logic [LANES*TAG_W-1:0]       grp_tag,
    output logic [LANES-1:0]             grp_seq
);

    localparam int EMIT_W = $clog2(LANES+1);

    logic [LANES-1:0]  simple;
    logic [LANES-1:0]  fits;
    logic [LANES-1:0]  over;
    logic [LANES-1:0]  lane_en;
    logic              enter;
    logic [EMIT_W-1:0] group_n;
    logic              seq_busy;
    logic [EMIT_W-1:0] seq_emit_n;
    logic [TAG_W-1:0]  seq_tag;
    logic              seq_start;

    for (genvar g = 0; g < LANES; g++) begin : g_class
        steer_slot_class #(
            .CNT_W   (CNT_W),
            .CPLX_MAX(CPLX_MAX)
        ) i_class (
            .valid_i (win_valid[g]),
            .uops_i  (win_uops[g*CNT_W +: CNT_W]),
            .simple_o(simple[g]),
            .fits_o  (fits[g]),
            .over_o  (over[g])
        );
    end

    steer_group_pick #(
        .LANES(LANES)
    ) i_pick (
        .simple_i (simple),
        .fits_i   (fits),
        .over_i   (over),
        .lane_en_o(lane_en),
        .enter_o  (enter),
        .n_o      (group_n)
    );

    assign seq_start = !seq_busy && enter;

    steer_ucode_seq #(
        .LANES(LANES),
        .CNT_W(CNT_W),
        .TAG_W(TAG_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (seq_start),
        .start_cnt_i(win_uops[CNT_W-1:0]),
        .start_tag_i(win_tag[TAG_W-1:0]),
        .advance_i  (out_ready),
        .busy_o     (seq_busy),
        .emit_n_o   (seq_emit_n),
        .tag_o      (seq_tag)
    );

    always_comb begin
        take_count = '0;
        grp_valid  = '0;
        grp_uops   = '0;
        grp_tag    = '0;
        grp_seq    = '0;
        if (seq_busy) begin
            for (int i = 0; i < LANES; i++) begin
                if (EMIT_W'(i) < seq_emit_n) begin
                    grp_valid[i]               = 1'b1;
                    grp_seq[i]                 = 1'b1;
                    grp_uops[i*CNT_W +: CNT_W] = CNT_W'(1);
                    grp_tag[i*TAG_W +: TAG_W]  = seq_tag;
                end
            end
        end else begin
            if (out_ready) begin
                take_count = enter ? EMIT_W'(1) : group_n;
            end
            for (int i = 0; i < LANES; i++) begin
                if (lane_en[i]) begin
                    grp_valid[i]               = 1'b1;
                    grp_uops[i*CNT_W +: CNT_W] = win_uops[i*CNT_W +: CNT_W];
                    grp_tag[i*TAG_W +: TAG_W]  = win_tag[i*TAG_W +: TAG_W];
                end
            end
        end
    end

endmodule

// File: rtl/decode_steer_checker.sv
module decode_steer_checker #(
    parameter int LANES    = 4,
    parameter int CNT_W    = 4,
    parameter int TAG_W    = 8,
    parameter int CPLX_MAX = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             win_valid,
    input logic [LANES*CNT_W-1:0]       win_uops,
    input logic [LANES*TAG_W-1:0]       win_tag,
    input logic                         out_ready,
    input logic [$clog2(LANES+1)-1:0]   take_count,
    input logic [LANES-1:0]             grp_valid,
    input logic [LANES*CNT_W-1:0]       grp_uops,
    input logic [LANES*TAG_W-1:0]       grp_tag,
    input logic [LANES-1:0]             grp_seq,
    input logic                         seq_busy
);

    assert_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !win_valid[0]) |-> (take_count == '0 && grp_valid == '0));

    assert_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid[0] && !grp_seq[0]) |-> (grp_uops[CNT_W-1:0] <= CNT_W'(CPLX_MAX)));

    assert_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && out_ready && win_valid[0] && win_uops[CNT_W-1:0] > CNT_W'(CPLX_MAX))
        |-> (grp_valid == '0 && take_count == 1));

    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && out_ready && win_valid[0] && win_uops[CNT_W-1:0] > CNT_W'(CPLX_MAX))
        |=> seq_busy);

    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && out_ready && !grp_valid[LANES-1]) |=> !seq_busy);

    assert_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (take_count == '0 && grp_seq == grp_valid));

    assert_hold_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> (take_count == '0));

    assert_hold_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !out_ready) |=> (seq_busy && $stable(grp_valid)));

    for (genvar g = 1; g < LANES; g++) begin : g_lane
        assert_simple_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid[g] && !grp_seq[g]) |-> (grp_uops[g*CNT_W +: CNT_W] <= CNT_W'(1)));

        assert_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!seq_busy && win_valid[g] && win_uops[g*CNT_W +: CNT_W] > CNT_W'(1))
            |-> !grp_valid[g]);

        assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!seq_busy && !win_valid[g-1]) |-> !grp_valid[g]);

        assert_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
            grp_valid[g] |-> grp_valid[g-1]);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_tag
        assert_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid[g] && !grp_seq[g])
            |-> (grp_tag[g*TAG_W +: TAG_W] == win_tag[g*TAG_W +: TAG_W] && win_valid[g]));
    end

endmodule

bind decode_steer decode_steer_checker #(
    .LANES   (LANES),
    .CNT_W   (CNT_W),
    .TAG_W   (TAG_W),
    .CPLX_MAX(CPLX_MAX)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_uops  (win_uops),
    .win_tag   (win_tag),
    .out_ready (out_ready),
    .take_count(take_count),
    .grp_valid (grp_valid),
    .grp_uops  (grp_uops),
    .grp_tag   (grp_tag),
    .grp_seq   (grp_seq),
    .seq_busy  (seq_busy)
);

// File: tb/test_decode_steer.sv
`timescale 1ns/1ps
module test_decode_steer;

    localparam int LANES  = 4;
    localparam int CNT_W  = 4;
    localparam int TAG_W  = 8;
    localparam int TK_W   = $clog2(LANES+1);
    localparam real TCLK  = 8.0;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [LANES-1:0]           win_valid = '0;
    logic [LANES*CNT_W-1:0]     win_uops = '0;
    logic [LANES*TAG_W-1:0]     win_tag = '0;
    logic                       out_ready = 1'b0;
    logic [TK_W-1:0]            take_count;
    logic [LANES-1:0]           grp_valid;
    logic [LANES*CNT_W-1:0]     grp_uops;
    logic [LANES*TAG_W-1:0]     grp_tag;
    logic [LANES-1:0]           grp_seq;

    int checks = 0;
    int errors = 0;

    // stimulus lanes
    bit v [LANES];
    int u [LANES];
    int t [LANES];
    bit rdy;

    // model stream state
    bit m_busy = 0;
    int m_rem  = 0;
    int m_tag  = 0;

    always #(TCLK/2) clk = ~clk;

    decode_steer #(.LANES(LANES), .CNT_W(CNT_W), .TAG_W(TAG_W), .CPLX_MAX(4)) i_decode_steer (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_uops(win_uops),
        .win_tag(win_tag), .out_ready(out_ready), .take_count(take_count),
        .grp_valid(grp_valid), .grp_uops(grp_uops), .grp_tag(grp_tag), .grp_seq(grp_seq)
    );

    task automatic set_win(input bit [3:0] vm, input int a, input int b, input int c, input int d,
                           input bit r);
        v[0] = vm[0]; v[1] = vm[1]; v[2] = vm[2]; v[3] = vm[3];
        u[0] = a; u[1] = b; u[2] = c; u[3] = d;
        for (int i = 0; i < LANES; i++) t[i] = (checks * 4 + i + 17) & 8'hff;
        rdy = r;
    endtask

    task automatic rand_win();
        int n;
        n = $urandom_range(0, LANES);
        for (int i = 0; i < LANES; i++) begin
            int p;
            v[i] = (i < n);
            p = $urandom_range(0, 99);
            if (p < 60)      u[i] = 1;
            else if (p < 85) u[i] = $urandom_range(2, 4);
            else             u[i] = $urandom_range(5, 15);
            t[i] = $urandom_range(0, 255);
        end
        if ($urandom_range(0, 9) == 0) v[$urandom_range(1, LANES-1)] = 0;
        rdy = ($urandom_range(0, 9) < 8);
    endtask

    task automatic run_cycle();
        int e_take;
        bit [LANES-1:0] e_val, e_seq;
        int e_u [LANES];
        int e_t [LANES];
        bit enter, ok, run;
        int k;
        string req;
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            win_valid[i] = v[i];
            win_uops[i*CNT_W +: CNT_W] = CNT_W'(u[i]);
            win_tag[i*TAG_W +: TAG_W]  = TAG_W'(t[i]);
        end
        out_ready = rdy;
        #1;
        e_take = 0; e_val = '0; e_seq = '0; enter = 0; k = 0;
        for (int i = 0; i < LANES; i++) begin e_u[i] = 0; e_t[i] = 0; end
        if (m_busy) begin
            k = (m_rem > LANES) ? LANES : m_rem;
            for (int i = 0; i < LANES; i++) if (i < k) begin
                e_val[i] = 1; e_seq[i] = 1; e_u[i] = 1; e_t[i] = m_tag;
            end
            req = rdy ? "R6 R7" : "R6 R7 R8";
        end else if (v[0] && u[0] > 4) begin
            enter = 1;
            e_take = rdy ? 1 : 0;
            req = rdy ? "R5" : "R5 R8";
        end else begin
            run = v[0];
            for (int i = 0; i < LANES; i++) begin
                if (i > 0) run = run && v[i] && (u[i] <= 1);
                if (run) begin
                    e_val[i] = 1; e_u[i] = u[i]; e_t[i] = t[i]; e_take++;
                end
            end
            if (!rdy) e_take = 0;
            req = !v[0] ? "R1" : "R2 R3 R4 R9";
            if (!rdy) req = {req, " R8"};
        end
        ok = (int'(take_count) == e_take) && (grp_valid == e_val) && (grp_seq == e_seq);
        for (int i = 0; i < LANES; i++) if (e_val[i]) begin
            if (int'(grp_uops[i*CNT_W +: CNT_W]) != e_u[i]) ok = 0;
            if (int'(grp_tag[i*TAG_W +: TAG_W]) != e_t[i]) ok = 0;
        end
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s take=%0d exp %0d valid=%b exp %b seq=%b exp %b uops=%h exp %0d,%0d,%0d,%0d tag=%h exp %0h,%0h,%0h,%0h",
                     req, take_count, e_take, grp_valid, e_val, grp_seq, e_seq, grp_uops,
                     e_u[0], e_u[1], e_u[2], e_u[3], grp_tag, e_t[0], e_t[1], e_t[2], e_t[3]);
        end
        if (rdy) begin
            if (m_busy) begin
                m_rem -= k;
                if (m_rem == 0) m_busy = 0;
            end else if (enter) begin
                m_busy = 1; m_rem = u[0]; m_tag = t[0];
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: state right after reset with an empty window
        set_win(4'b0000, 1, 1, 1, 1, 1); run_cycle();
        // R2: four single micro-op instructions
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        // R3: complex lead, simple followers
        set_win(4'b1111, 3, 1, 0, 1, 1); run_cycle();
        set_win(4'b1111, 4, 1, 1, 1, 1); run_cycle();
        // R4: complex in lane 2, oversized in lane 1
        set_win(4'b1111, 1, 1, 3, 1, 1); run_cycle();
        set_win(4'b1111, 1, 6, 1, 1, 1); run_cycle();
        // R9: gap in lane 1
        set_win(4'b1101, 1, 1, 1, 1, 1); run_cycle();
        // R5 R6 R8: count 10 streams 4,4,2 with one stalled cycle
        set_win(4'b1111, 10, 1, 1, 1, 1); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 0); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        // R5 R6: boundary count 5 streams 4 then 1
        set_win(4'b0011, 5, 1, 1, 1, 1); run_cycle();
        set_win(4'b0000, 1, 1, 1, 1, 1); run_cycle();
        set_win(4'b0000, 1, 1, 1, 1, 1); run_cycle();
        set_win(4'b0000, 1, 1, 1, 1, 1); run_cycle();
        // R8: stall in grouping mode, oversized lead with ready low
        set_win(4'b1111, 1, 1, 1, 1, 0); run_cycle();
        set_win(4'b1111, 9, 1, 1, 1, 0); run_cycle();
        set_win(4'b1111, 1, 1, 1, 1, 1); run_cycle();
        for (int n = 0; n < 4000; n++) begin
            rand_win();
            run_cycle();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(TCLK * 200000.0);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule